// File: doc/BRIEF.md
# Serial Receive Engine with Error Flags

This block turns an asynchronous serial line into characters for a host. The line is first passed through a two-stage synchroniser. A start bit is taken from a falling edge of the synchronised line and is confirmed at its mid-point by an oversampling counter, which is advanced by an external tick running at the oversampling rate. Each data bit is then sampled at its centre, least significant bit first, followed by an optional parity bit and a stop bit. Both the data width and the parity mode are fixed when the block is built.

The receive shift register and the host-visible holding register form a double buffer, so one character can be shifting in while the previous one waits to be read. Every finished character is copied into the holding register and raises a ready flag. A host read strobe consumes the character. Four sticky error flags report stop-bit, parity, overrun and line-break conditions. They stay set until the host pulses a clear strobe.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, rxData is 0 and readReady, frameErr, parityErr, overrun and breakDet are all 0.
- R2: A frame sent least significant bit first (start bit 0, DATA_BITS data bits, optional parity bit, stop bit 1) puts the character on rxData and sets readReady to 1.
- R3: If a character finishes while readReady is still 1 and no read strobe arrives in that cycle, the new character replaces the old one on rxData and overrun becomes 1.
- R4: A one-cycle hostRead pulse clears readReady to 0 and leaves rxData unchanged.
- R5: A stop bit sampled as 0 sets frameErr to 1, and the character is still delivered with readReady set.
- R6: With PARITY_MODE 1 (even), the count of ones over the data bits and the parity bit must be even; with 2 (odd) it must be odd. A mismatch sets parityErr. With PARITY_MODE 0 there is no parity bit and parityErr stays 0.
- R7: breakDet is set only when the synchronised line stays 0 for more than one full frame time (FRAME_BITS × OVERSAMPLE ticks). A character of all zeros with a valid stop bit does not set it.
- R8: frameErr, parityErr, overrun and breakDet hold their value until a hostClear pulse clears them, and hostClear does not change readReady or rxData.
- R9: A low pulse shorter than half a bit period is rejected at the mid-start check and delivers no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle pulse at OVERSAMPLE times the bit rate |
| rxIn | input | 1 | Serial line, idle high |
| hostRead | input | 1 | Pulse: host has taken rxData |
| hostClear | input | 1 | Pulse: clear the sticky error flags |
| rxData | output | DATA_BITS | Holding register with the last character |
| readReady | output | 1 | An unread character is waiting |
| frameErr | output | 1 | Sticky: a stop bit was sampled low |
| parityErr | output | 1 | Sticky: a parity bit was wrong |
| overrun | output | 1 | Sticky: an unread character was overwritten |
| breakDet | output | 1 | Sticky: the line was held low for longer than a frame |

## Verification
The bench targets the conditions a receiver most often gets wrong. A line held low for ten bit periods with a valid stop bit must not count as a break, and a design that counts only the data bits would flag one there. A short glitch must be dropped at the mid-start check, or a careless design would assemble a ghost character out of idle-high bits. A second character must overwrite an unread one and raise overrun, where a buggy design would either keep the old byte or lose the flag. Random bytes with occasional deliberately wrong parity bits check that the bit order is right and that parity is computed over the correct set of bits.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int PAR_NONE = 0;
  localparam int PAR_EVEN = 1;
  localparam int PAR_ODD  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } rxState_e;

  typedef struct packed {
    logic frameBegin;
    logic sampleData;
    logic sampleParity;
    logic finishFrame;
  } rxStrobe_t;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int PARITY_MODE = PAR_EVEN,
  parameter int OVERSAMPLE  = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      rxSync,
  output rxStrobe_t strobe
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_BITS - 1);
  localparam bit HAS_PARITY = (PARITY_MODE != PAR_NONE);

  rxState_e         state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             rxPrev;
  logic             midStart, bitEnd;

  assign midStart = (state == ST_START) && baudTick && (tickCnt == HALF_LAST);
  assign bitEnd   = baudTick && (tickCnt == FULL_LAST);

  always_comb begin
    strobe              = '0;
    strobe.frameBegin   = midStart && !rxSync;
    strobe.sampleData   = (state == ST_DATA) && bitEnd;
    strobe.sampleParity = (state == ST_PARITY) && bitEnd;
    strobe.finishFrame  = (state == ST_STOP) && bitEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      rxPrev  <= 1'b1;
    end else begin
      rxPrev <= rxSync;
      case (state)
        ST_IDLE: begin
          if (rxPrev && !rxSync) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (midStart) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= rxSync ? ST_IDLE : ST_DATA;
          end else if (baudTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bitEnd) begin
            tickCnt <= '0;
            if (bitIdx == LAST_BIT) state <= HAS_PARITY ? ST_PARITY : ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else if (baudTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_PARITY: begin
          if (bitEnd) begin
            tickCnt <= '0;
            state   <= ST_STOP;
          end else if (baudTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (bitEnd) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else if (baudTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: at most one datapath action per cycle
  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R9: a start bit seen high at its mid-point sends the engine back to hunting
  p_glitch_reject_r9: assert property (@(posedge clk) disable iff (!rstN)
    (midStart && rxSync) |=> (state == ST_IDLE));
endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int PARITY_MODE = PAR_EVEN,
  parameter int OVERSAMPLE  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic                 rxIn,
  input  logic                 hostRead,
  input  logic                 hostClear,
  input  rxStrobe_t            strobe,
  output logic                 rxSync,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 readReady,
  output logic                 frameErr,
  output logic                 parityErr,
  output logic                 overrun,
  output logic                 breakDet
);
  localparam bit HAS_PARITY = (PARITY_MODE != PAR_NONE);
  localparam bit ODD_PAR    = (PARITY_MODE == PAR_ODD);
  localparam int FRAME_BITS = DATA_BITS + 2 + (HAS_PARITY ? 1 : 0);
  localparam int BRK_LIMIT  = FRAME_BITS * OVERSAMPLE;
  localparam int LOW_W      = $clog2(BRK_LIMIT + 2);
  localparam logic [LOW_W-1:0] LOW_AT_LIMIT = LOW_W'(BRK_LIMIT);
  localparam logic [LOW_W-1:0] LOW_SAT      = LOW_W'(BRK_LIMIT + 1);

  logic [1:0]           syncQ;
  logic [DATA_BITS-1:0] shiftReg;
  logic                 parAcc, parBad;
  logic [LOW_W-1:0]     lowCnt;
  logic                 brkSet, ovrSet, feSet, peSet;

  assign rxSync = syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBad   <= 1'b0;
    end else begin
      if (strobe.frameBegin) begin
        parAcc <= 1'b0;
        parBad <= 1'b0;
      end
      if (strobe.sampleData) begin
        shiftReg <= {rxSync, shiftReg[DATA_BITS-1:1]};
        parAcc   <= parAcc ^ rxSync;
      end
      if (strobe.sampleParity)
        parBad <= HAS_PARITY && ((parAcc ^ rxSync) ^ ODD_PAR);
    end
  end

  assign ovrSet = strobe.finishFrame && readReady && !hostRead;
  assign feSet  = strobe.finishFrame && !rxSync;
  assign peSet  = strobe.finishFrame && parBad;
  assign brkSet = baudTick && !rxSync && (lowCnt == LOW_AT_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= '0;
    else if (rxSync) lowCnt <= '0;
    else if (baudTick && lowCnt != LOW_SAT) lowCnt <= lowCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      readReady <= 1'b0;
      frameErr  <= 1'b0;
      parityErr <= 1'b0;
      overrun   <= 1'b0;
      breakDet  <= 1'b0;
    end else begin
      if (strobe.finishFrame) rxData <= shiftReg;
      if (strobe.finishFrame) readReady <= 1'b1;
      else if (hostRead)      readReady <= 1'b0;
      if (feSet)          frameErr <= 1'b1;
      else if (hostClear) frameErr <= 1'b0;
      if (peSet)          parityErr <= 1'b1;
      else if (hostClear) parityErr <= 1'b0;
      if (ovrSet)         overrun <= 1'b1;
      else if (hostClear) overrun <= 1'b0;
      if (brkSet)         breakDet <= 1'b1;
      else if (hostClear) breakDet <= 1'b0;
    end
  end

  p_ready_on_finish_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finishFrame |=> readReady);
  p_overrun_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finishFrame && readReady && !hostRead) |=> overrun);
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostRead && !strobe.finishFrame) |=> !readReady);
  p_parity_at_finish_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> $past(strobe.finishFrame));
  p_break_needs_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakDet) |-> !$past(rxSync));
  p_sticky_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !hostClear) |=> frameErr);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int PARITY_MODE = PAR_EVEN,
  parameter int OVERSAMPLE  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic                 rxIn,
  input  logic                 hostRead,
  input  logic                 hostClear,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 readReady,
  output logic                 frameErr,
  output logic                 parityErr,
  output logic                 overrun,
  output logic                 breakDet
);
  rxStrobe_t strobe;
  logic      rxSync;

  uart_rx_ctrl #(
    .DATA_BITS(DATA_BITS), .PARITY_MODE(PARITY_MODE), .OVERSAMPLE(OVERSAMPLE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxSync(rxSync), .strobe(strobe)
  );

  uart_rx_datapath #(
    .DATA_BITS(DATA_BITS), .PARITY_MODE(PARITY_MODE), .OVERSAMPLE(OVERSAMPLE)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxIn(rxIn),
    .hostRead(hostRead), .hostClear(hostClear), .strobe(strobe),
    .rxSync(rxSync), .rxData(rxData), .readReady(readReady),
    .frameErr(frameErr), .parityErr(parityErr), .overrun(overrun),
    .breakDet(breakDet)
  );
endmodule

// File: tb/test_uart_rx_core.sv
module test_uart_rx_core;
  localparam int DATA_BITS = 8;
  localparam int OS        = 16;
  localparam int BIT_CLKS  = 2 * OS;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       rxIn = 1'b1;
  logic       hostRead = 1'b0;
  logic       hostClear = 1'b0;
  logic [7:0] rxData;
  logic       readReady, frameErr, parityErr, overrun, breakDet;
  int         testCount = 0;
  int         failCount = 0;
  bit         finished = 1'b0;

  uart_rx_core #(.DATA_BITS(DATA_BITS), .PARITY_MODE(1), .OVERSAMPLE(OS)) i_uart_rx_core (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxIn(rxIn),
    .hostRead(hostRead), .hostClear(hostClear), .rxData(rxData),
    .readReady(readReady), .frameErr(frameErr), .parityErr(parityErr),
    .overrun(overrun), .breakDet(breakDet)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) baudTick <= ~baudTick;

  function automatic bit evenPar(input logic [7:0] d);
    return ^d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic driveBit(input bit v);
    rxIn = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit badPar, input bit stopVal);
    driveBit(1'b0);
    for (int i = 0; i < DATA_BITS; i++) driveBit(d[i]);
    driveBit(evenPar(d) ^ badPar);
    driveBit(stopVal);
    driveBit(1'b1);
  endtask

  task automatic pulseRead();
    hostRead = 1'b1; @(negedge clk); hostRead = 1'b0; @(negedge clk);
  endtask

  task automatic pulseClear();
    hostClear = 1'b1; @(negedge clk); hostClear = 1'b0; @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    testCount++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 rxData", rxData, 0);
    check("R1 readReady", readReady, 0);
    check("R1 errors", {frameErr, parityErr, overrun, breakDet}, 0);

    // R2 directed character
    sendFrame(8'hA5, 1'b0, 1'b1);
    check("R2 data", rxData, 8'hA5);
    check("R2 ready", readReady, 1);
    check("R2 no errors", {frameErr, parityErr, overrun, breakDet}, 0);

    // R4 read clears ready, data kept
    pulseRead();
    check("R4 ready", readReady, 0);
    check("R4 data kept", rxData, 8'hA5);

    // R3 overrun
    sendFrame(8'h3C, 1'b0, 1'b1);
    sendFrame(8'hC1, 1'b0, 1'b1);
    check("R3 data replaced", rxData, 8'hC1);
    check("R3 overrun", overrun, 1);
    check("R3 ready", readReady, 1);

    // R8 clear leaves ready and data alone
    pulseClear();
    check("R8 overrun cleared", overrun, 0);
    check("R8 ready kept", readReady, 1);
    check("R8 data kept", rxData, 8'hC1);
    pulseRead();

    // R6 parity error
    sendFrame(8'h5A, 1'b1, 1'b1);
    check("R6 parityErr", parityErr, 1);
    check("R6 data", rxData, 8'h5A);
    pulseRead();
    // R8 sticky across a good frame
    sendFrame(8'h11, 1'b0, 1'b1);
    check("R8 parityErr sticky", parityErr, 1);
    pulseRead();
    pulseClear();
    check("R8 parityErr cleared", parityErr, 0);

    // R5 framing error
    sendFrame(8'hFF, 1'b0, 1'b0);
    check("R5 frameErr", frameErr, 1);
    check("R5 ready", readReady, 1);
    check("R5 data", rxData, 8'hFF);
    pulseRead();
    pulseClear();

    // R7 all-zero character is not a break
    sendFrame(8'h00, 1'b0, 1'b1);
    check("R7 no break", breakDet, 0);
    check("R7 zero char", rxData, 8'h00);
    pulseRead();

    // R7 real break
    rxIn = 1'b0;
    repeat (12 * BIT_CLKS) @(negedge clk);
    check("R7 break", breakDet, 1);
    check("R7 break frame error", frameErr, 1);
    driveBit(1'b1);
    driveBit(1'b1);
    pulseRead();
    pulseClear();
    check("R8 break cleared", breakDet, 0);

    // R9 glitch rejection
    rxIn = 1'b0;
    repeat (8) @(negedge clk);
    rxIn = 1'b1;
    repeat (15 * BIT_CLKS) @(negedge clk);
    check("R9 no char", readReady, 0);
    check("R9 no errors", {frameErr, parityErr, overrun, breakDet}, 0);

    // R2 / R6 random characters
    for (int n = 0; n < 16; n++) begin
      logic [7:0] d;
      bit bad;
      d   = 8'($urandom);
      bad = ($urandom % 4) == 0;
      sendFrame(d, bad, 1'b1);
      check("R2 random data", rxData, d);
      check("R6 random parity", parityErr, bad);
      pulseRead();
      pulseClear();
    end

    finish();
  end
endmodule